// File: doc/BRIEF.md
# One-Time-Enable Watchdog Timer

This block is a watchdog that stays dormant after a system reset and is armed by software through a two-byte unlock sequence written to its service register. Once armed it cannot be turned off by any write. Only a system reset turns it off. The same two-byte sequence, written again, services the watchdog by restarting its count from zero.

The count advances only on machine-cycle ticks supplied by the surrounding clock logic. A gated tick therefore freezes the watchdog during low-power states. The timeout is a power of two. A base width of 14 bits is widened by a 3-bit select held in a timeout register, which gives eight ranges from 2^14 to 2^21 ticks.

When the count runs out, the block drives a reset request of fixed length to the chip's reset logic. It then starts counting again from zero. If software never services it, it fires again after another full timeout.

Top module: `sentinel_wdt`

## Requirements
- R1: After reset the watchdog is disabled, and `rst_out` stays low whatever the tick input does.
- R2: A write of 0x1E followed by a write of 0xE1 to the service register (address `KICK_ADDR`) enables the watchdog and starts its count from zero.
- R3: In the service register, any byte other than the expected next byte of the sequence cancels a partial sequence, and the sequence must start again with 0x1E. A 0x1E written while the block is waiting for 0xE1 starts the sequence afresh. Writes to other addresses leave a partial sequence untouched.
- R4: The timeout register (address `CFG_ADDR`) holds a select S in write-data bits [SEL_W-1:0]. S resets to 0. While the block is enabled, the reset request rises after exactly 2^(BASE_W+S) ticks have been counted since the last completed sequence.
- R5: Only cycles with `tick` high advance the count. Cycles without a tick leave the count unchanged.
- R6: Completing the sequence again while the block is enabled restarts the count from zero, so the next expiry comes a full timeout after that write.
- R7: `rst_out` is high for exactly `PULSE_CYCLES` clock cycles. It rises in the cycle after the clock edge that counted the final tick, and ticks are ignored while it is high.
- R8: The watchdog cannot be disabled by writes. After a reset request ends it counts again from zero and fires again after another full timeout.
- R9: A system reset returns the block to the disabled state and sets S back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tick | input | 1 | Machine-cycle tick, high for one clock per machine cycle |
| rst_out | output | 1 | Reset request to the chip reset logic |

## Verification
On every cycle, the assertions check the following:
- the enable is sticky;
- a completed sequence leaves the block enabled with a zero count;
- the count holds when no tick arrives;
- a reset request appears only while enabled, rises only after an expiry and never lasts longer than its fixed length.

The exact timeout for each of the eight select values, the rejection of broken or interleaved sequences and the restart on a second sequence can only be shown by the bench's scenarios. The same goes for re-firing after a request and the return to the disabled state on reset. The bench measures these with a narrow base width, sweeping every select value at full and reduced tick rates.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    // Width of a counter able to reach 2^(base + max_select) - 1.
    function automatic int span_bits(input int base_w, input int sel_w);
        span_bits = base_w + (1 << sel_w) - 1;
    endfunction

    // Width of a down counter holding values 0..n.
    function automatic int hold_bits(input int n);
        hold_bits = (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter int                SEL_W      = 3,
    parameter logic [ADDR_W-1:0] KICK_ADDR  = ADDR_W'(8'h30),
    parameter logic [ADDR_W-1:0] CFG_ADDR   = ADDR_W'(8'h31),
    parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'(8'h1E),
    parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'(8'hE1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              kick,
    output logic [SEL_W-1:0]  sel
);

    typedef struct packed {
        seq_state_e       seq;
        logic [SEL_W-1:0] sel;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  kick_d;
    logic  hit_kick;
    logic  hit_cfg;

    always_comb begin
        regs_d   = regs_q;
        kick_d   = 1'b0;
        hit_kick = wr_en && (wr_addr == KICK_ADDR);
        hit_cfg  = wr_en && (wr_addr == CFG_ADDR);

        if (hit_kick) begin
            unique case (regs_q.seq)
                SEQ_IDLE: begin
                    if (wr_data == KEY_FIRST) begin
                        regs_d.seq = SEQ_ARMED;
                    end
                end
                SEQ_ARMED: begin
                    if (wr_data == KEY_SECOND) begin
                        regs_d.seq = SEQ_IDLE;
                        kick_d     = 1'b1;
                    end else if (wr_data == KEY_FIRST) begin
                        regs_d.seq = SEQ_ARMED;
                    end else begin
                        regs_d.seq = SEQ_IDLE;
                    end
                end
                default: regs_d.seq = SEQ_IDLE;
            endcase
        end

        if (hit_cfg) begin
            regs_d.sel = wr_data[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{seq: SEQ_IDLE, sel: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign kick = kick_d;
    assign sel  = regs_q.sel;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_W = 14,
    parameter int SEL_W  = 3,
    localparam int CNT_W = span_bits(BASE_W, SEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic             tick,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    output logic             enabled,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t             cnt_d, cnt_q;
    logic [CNT_W-1:0] term;
    logic             advance;
    logic             expire_d;

    always_comb begin
        cnt_d    = cnt_q;
        expire_d = 1'b0;
        // Terminal value is 2^(BASE_W+sel) - 1.
        term     = ~({CNT_W{1'b1}} << (BASE_W + int'(sel)));
        advance  = cnt_q.en && tick && !hold;

        if (kick) begin
            cnt_d.en  = 1'b1;
            cnt_d.cnt = '0;
        end else if (advance) begin
            if (cnt_q.cnt == term) begin
                expire_d  = 1'b1;
                cnt_d.cnt = '0;
            end else begin
                cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '{en: 1'b0, cnt: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign enabled = cnt_q.en;
    assign count   = cnt_q.cnt;
    assign expire  = expire_d;

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
    import wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 96,
    localparam int PW = hold_bits(PULSE_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t pulse_d, pulse_q;

    always_comb begin
        pulse_d = pulse_q;
        if (fire) begin
            pulse_d.left = PW'(PULSE_CYCLES);
        end else if (pulse_q.left != '0) begin
            pulse_d.left = pulse_q.left - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '{left: '0};
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign active = (pulse_q.left != '0);

endmodule

// File: rtl/sentinel_wdt.sv
module sentinel_wdt
    import wdt_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 8,
    parameter int                BASE_W       = 14,
    parameter int                SEL_W        = 3,
    parameter int                PULSE_CYCLES = 96,
    parameter logic [ADDR_W-1:0] KICK_ADDR    = ADDR_W'(8'h30),
    parameter logic [ADDR_W-1:0] CFG_ADDR     = ADDR_W'(8'h31),
    parameter logic [DATA_W-1:0] KEY_FIRST    = DATA_W'(8'h1E),
    parameter logic [DATA_W-1:0] KEY_SECOND   = DATA_W'(8'hE1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              rst_out
);

    localparam int CNT_W = span_bits(BASE_W, SEL_W);

    logic             kick;
    logic [SEL_W-1:0] sel;
    logic             enabled;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             pulse_on;

    wdt_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .KICK_ADDR (KICK_ADDR),
        .CFG_ADDR  (CFG_ADDR),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .kick   (kick),
        .sel    (sel)
    );

    wdt_counter #(
        .BASE_W(BASE_W),
        .SEL_W (SEL_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (kick),
        .tick   (tick),
        .hold   (pulse_on),
        .sel    (sel),
        .enabled(enabled),
        .count  (count),
        .expire (expire)
    );

    wdt_pulse #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire),
        .active(pulse_on)
    );

    assign rst_out = pulse_on;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W        = 21,
    parameter int PULSE_CYCLES = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             kick,
    input logic             enabled,
    input logic [CNT_W-1:0] count,
    input logic             expire,
    input logic             rst_out
);

    int high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run <= 0;
        end else if (rst_out) begin
            high_run <= high_run + 1;
        end else begin
            high_run <= 0;
        end
    end

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !rst_out);

    a_r8_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> enabled);

    a_r2_kick_arms_zero: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (enabled && count == '0));

    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !tick && !kick) |=> $stable(count));

    a_r7_rise_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(expire));

    a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> (high_run < PULSE_CYCLES));

endmodule

bind sentinel_wdt wdt_checker #(
    .CNT_W       (CNT_W),
    .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .kick   (kick),
    .enabled(enabled),
    .count  (count),
    .expire (expire),
    .rst_out(rst_out)
);

// File: tb/sim_sentinel_wdt.sv
`timescale 1ns/1ps
module sim_sentinel_wdt;

    localparam int          ADDR_W = 8;
    localparam int          DATA_W = 8;
    localparam int          BASE_W = 3;
    localparam int          SEL_W  = 3;
    localparam int          PULSE  = 5;
    localparam logic [7:0]  KADDR  = 8'h30;
    localparam logic [7:0]  CADDR  = 8'h31;
    localparam logic [7:0]  OTHER  = 8'h44;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              tick = 1'b0;
    logic              rst_out;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sentinel_wdt #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BASE_W      (BASE_W),
        .SEL_W       (SEL_W),
        .PULSE_CYCLES(PULSE),
        .KICK_ADDR   (KADDR),
        .CFG_ADDR    (CADDR)
    ) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .tick   (tick),
        .rst_out(rst_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        tick  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic service();
        wr(KADDR, 8'h1E);
        wr(KADDR, 8'hE1);
    endtask

    // Cycles until rst_out is seen, tick high once every 'period' cycles.
    task automatic measure(input int period, input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            tick = ((i % period) == 0);
            @(negedge clk);
            n = i;
            if (rst_out) break;
        end
        tick = 1'b0;
    endtask

    task automatic width(output int w);
        w = 1;
        tick = 1'b1;
        for (int i = 0; i < 4 * PULSE; i++) begin
            @(negedge clk);
            if (rst_out) w++;
            else break;
        end
    endtask

    task automatic quiet(input int len, output int highs);
        highs = 0;
        tick = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (rst_out) highs++;
        end
    endtask

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        int n;
        int w;
        int h;

        // R1: dormant after reset
        do_reset();
        check(rst_out == 1'b0, "R1 reset value", int'(rst_out), 0);
        quiet(3000, h);
        check(h == 0, "R1 no request while disabled", h, 0);

        // R4 R7 R8: sweep every select value
        for (int s = 0; s < 8; s++) begin
            do_reset();
            wr(CADDR, 8'(s));
            tick = 1'b1;
            service();
            measure(1, 5000, n);
            check(n == (1 << (BASE_W + s)), $sformatf("R4 timeout sel=%0d", s), n, 1 << (BASE_W + s));
            width(w);
            check(w == PULSE, $sformatf("R7 pulse width sel=%0d", s), w, PULSE);
            if (s < 3) begin
                measure(1, 5000, n);
                check(n == (1 << (BASE_W + s)), $sformatf("R8 refire sel=%0d", s), n, 1 << (BASE_W + s));
                width(w);
            end
        end

        // R5: reduced tick rate
        for (int p = 2; p <= 4; p++) begin
            do_reset();
            wr(CADDR, 8'd1);
            service();
            measure(p, 5000, n);
            check(n == 16 * p, $sformatf("R5 tick period %0d", p), n, 16 * p);
        end

        // R3: broken sequence does not enable
        do_reset();
        wr(KADDR, 8'h1E);
        wr(KADDR, 8'h55);
        wr(KADDR, 8'hE1);
        quiet(200, h);
        check(h == 0, "R3 wrong byte aborts", h, 0);
        wr(KADDR, 8'hE1);
        quiet(200, h);
        check(h == 0, "R3 second byte alone", h, 0);

        // R3: 0x1E while armed restarts the sequence
        do_reset();
        wr(KADDR, 8'h1E);
        wr(KADDR, 8'h1E);
        wr(KADDR, 8'hE1);
        measure(1, 5000, n);
        check(n == 8, "R3 repeated first byte", n, 8);

        // R3: write to another address keeps the partial sequence
        do_reset();
        wr(KADDR, 8'h1E);
        wr(OTHER, 8'h00);
        wr(KADDR, 8'hE1);
        measure(1, 5000, n);
        check(n == 8, "R3 interleaved other address", n, 8);

        // R2 R6: second sequence restarts the count
        do_reset();
        wr(CADDR, 8'd2);
        tick = 1'b1;
        service();
        quiet(20, h);
        check(h == 0, "R2 no early request", h, 0);
        service();
        measure(1, 5000, n);
        check(n == 32, "R6 restart from zero", n, 32);

        // R9: reset disables and clears the select
        do_reset();
        wr(CADDR, 8'd5);
        service();
        quiet(10, h);
        do_reset();
        quiet(3000, h);
        check(h == 0, "R9 disabled after reset", h, 0);
        service();
        measure(1, 5000, n);
        check(n == 8, "R9 select back to zero", n, 8);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule